// File: doc/BRIEF.md
# Gated interval timer channel

This block is a single channel of a byte-programmed interval timer, paired with an 8-bit system control register. That register both gates the channel and steers its output to a speaker pin. Software programs the channel through a byte bus. A control-word write picks the counting mode. Two data writes then supply a 16-bit reload value, low byte first. The counter steps down once for every strobe on a slow input-clock enable, but only while the gate bit is set. When the gate bit is cleared, the count and the output both hold their values. Setting the gate bit again lets counting carry on from the held value.

The channel has two modes. In rate-generator mode the output drops low for one input clock once per period. In square-wave mode the output stays high for the first half of the period and low for the rest. A read-back command latches a status byte and the count, so software can read a consistent snapshot while the counter keeps running. Without a latch, data reads return the live count, low byte then high byte. The speaker pin carries the timer output masked by a routing bit.

Top module: `pit_gate_channel`

## Requirements
- R1: After reset, `timer_out` is 1 and `spkr_out` is 0. The system register (address 2) reads 0x00. A read-back returns status 0xC4 followed by count bytes 0x00 and 0x00.
- R2: A control word sent to address 1 with bits 7:6 = 10 reprograms the channel. Bits 3:1 = 011 select square-wave mode and bits 3:1 = 010 select rate-generator mode. After such a write, `timer_out` is 1, the null-count flag is set and counting stops until a new reload value has been written.
- R3: Two data writes to address 0 give the reload value, low byte first and high byte second. On the first gated tick after the high-byte write, the count takes the reload value and the null-count flag clears.
- R4: In square-wave mode with reload N, `timer_out` is high while the count is greater than N/2 (rounded down) and low otherwise. The count reloads after it reaches 1. This gives ceil(N/2) high ticks and floor(N/2) low ticks.
- R5: In rate-generator mode, `timer_out` is low for exactly one tick while the count equals 1. On the next tick the count reloads and the output returns high.
- R6: The count and `timer_out` change only on a `tick_en` strobe while system-register bit 0 is 1. A tick on the same edge as a write to that bit uses the gate value held before the write.
- R7: `spkr_out` equals `timer_out` AND system-register bit 1. The speaker pin follows a write to the system register from the next cycle.
- R8: Writing 0x0F to the system register after the gate was cleared resumes counting from the held count.
- R9: A read-back command at address 1 has bits 7:6 = 11, bit 5 = 0 to latch the count, bit 4 = 0 to latch the status, and bit 3 = 1 to select this channel. After it, the next data read returns the status byte, then the count low byte, then the count high byte. The latched values do not change while counting continues. A read-back with bit 3 = 0 has no effect.
- R10: The status byte holds `timer_out` in bit 7, the null-count flag in bit 6, and bits 5:0 of the last control word in bits 5:0.
- R11: All 8 bits of the system register read back as written, including the bits that control nothing.
- R12: Control words with bits 7:6 = 00 or 01 are ignored.
- R13: Without a latch, data reads return the live count, low byte then high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for bus and counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Input-clock enable strobe, one counter step per strobe |
| bus_addr | input | 2 | 0 = channel data, 1 = control word, 2 = system register |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe; advances the read sequence at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high |
| timer_out | output | 1 | Channel output |
| spkr_out | output | 1 | Speaker output: timer output masked by the routing bit |

## Verification
Two functions can land on the same clock edge: a counting tick, and a system-register write that flips the gate. The bench drives `tick_en` in the same cycle as a write that clears the gate bit, and again in the same cycle as a write that sets it. It then reads the live count. The first tick must still count and the second must not, because the counter uses the gate value registered before the edge. A second overlap is a read-back latch taken while the counter keeps stepping. Here the bench expects the snapshot value and not the live one.

// File: rtl/pit_gate_pkg.sv
package pit_gate_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;

  localparam logic [1:0] ADR_DATA = 2'd0;
  localparam logic [1:0] ADR_CTRL = 2'd1;
  localparam logic [1:0] ADR_SYS  = 2'd2;

  // control-word select field values (bits 7:6)
  localparam logic [1:0] SEL_THIS = 2'b10;
  localparam logic [1:0] SEL_RDBK = 2'b11;

  // read-back field positions
  localparam int unsigned RB_NCNT = 5;
  localparam int unsigned RB_NSTS = 4;
  localparam int unsigned RB_CHAN = 3;

  // control bits 5:0 after reset: binary, rate generator, no access set
  localparam logic [5:0] CW_RESET = 6'b000100;

  typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} byte_ph_e;
endpackage

// File: rtl/pit_sysctl.sv
module pit_sysctl
  import pit_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] reg_q,
  output logic              gate,
  output logic              spk_en
);
  logic [BYTE_W-1:0] reg_d;

  always_comb begin
    reg_d = reg_q;
    if (wr) reg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  assign gate   = reg_q[0];
  assign spk_en = reg_q[1];
endmodule

// File: rtl/pit_prog.sv
module pit_prog
  import pit_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wdata,
  output logic [5:0]        cw_q,
  output logic              cfg_wr,
  output logic              rb_cnt,
  output logic              rb_sts,
  output logic              load_wr,
  output logic [BYTE_W-1:0] lo_q
);
  logic [1:0]        sel;
  logic              rb_hit;
  logic [5:0]        cw_d;
  logic [BYTE_W-1:0] lo_d;
  byte_ph_e          wph_q, wph_d;

  assign sel     = wdata[BYTE_W-1 -: 2];
  assign cfg_wr  = wr_ctrl && (sel == SEL_THIS);
  assign rb_hit  = wr_ctrl && (sel == SEL_RDBK) && wdata[RB_CHAN];
  assign rb_cnt  = rb_hit && !wdata[RB_NCNT];
  assign rb_sts  = rb_hit && !wdata[RB_NSTS];
  assign load_wr = wr_data && (wph_q == PH_HI);

  always_comb begin
    cw_d  = cw_q;
    lo_d  = lo_q;
    wph_d = wph_q;
    if (cfg_wr) begin
      cw_d  = wdata[5:0];
      wph_d = PH_LO;
    end else if (wr_data) begin
      if (wph_q == PH_LO) begin
        lo_d  = wdata;
        wph_d = PH_HI;
      end else begin
        wph_d = PH_LO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q  <= CW_RESET;
      lo_q  <= '0;
      wph_q <= PH_LO;
    end else begin
      cw_q  <= cw_d;
      lo_q  <= lo_d;
      wph_q <= wph_d;
    end
  end
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          cfg_wr,
  input  logic          load_wr,
  input  logic          square,
  input  logic [CW-1:0] reload_in,
  output logic [CW-1:0] cnt_q,
  output logic          out_q,
  output logic          null_q
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] TWO = {{(CW-2){1'b0}}, 2'b10};

  logic [CW-1:0] rel_q, rel_d, cnt_d;
  logic          out_d, null_d, arm_q, arm_d, run_q, run_d;
  logic          step;

  // a zero reload stands for 2**CW
  function automatic logic [CW:0] eff(input logic [CW-1:0] v);
    return (v == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, v};
  endfunction

  function automatic logic level(input logic [CW-1:0] c, input logic [CW-1:0] r,
                                 input logic sq);
    if (sq) return eff(c) > (eff(r) >> 1);
    return c != ONE;
  endfunction

  assign step = tick_en && gate;

  always_comb begin
    rel_d  = rel_q;
    cnt_d  = cnt_q;
    out_d  = out_q;
    null_d = null_q;
    arm_d  = arm_q;
    run_d  = run_q;
    if (cfg_wr) begin
      arm_d  = 1'b0;
      run_d  = 1'b0;
      null_d = 1'b1;
      out_d  = 1'b1;
    end else begin
      if (step) begin
        if (arm_q) begin
          cnt_d  = rel_q;
          run_d  = 1'b1;
          arm_d  = 1'b0;
          null_d = 1'b0;
          out_d  = level(rel_q, rel_q, square);
        end else if (run_q) begin
          cnt_d = (cnt_q == ONE) ? rel_q : cnt_q - ONE;
          out_d = level(cnt_d, rel_q, square);
        end
      end
      if (load_wr) begin
        rel_d  = reload_in;
        arm_d  = 1'b1;
        null_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q  <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b1;
      null_q <= 1'b1;
      arm_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      rel_q  <= rel_d;
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      null_q <= null_d;
      arm_q  <= arm_d;
      run_q  <= run_d;
    end
  end

  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_en && gate) && !cfg_wr |=> $stable(cnt_q) && $stable(out_q));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q && tick_en && gate && !cfg_wr && !load_wr |=> (cnt_q == $past(rel_q)) && !null_q);

  // R5
  rate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !arm_q && !square && (cnt_q == TWO) && tick_en && gate && !cfg_wr |=> !out_q);

  // R4
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !arm_q |-> eff(cnt_q) <= eff(rel_q));
endmodule

// File: rtl/pit_readout.sv
module pit_readout
  import pit_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              cfg_wr,
  input  logic              rb_cnt,
  input  logic              rb_sts,
  input  logic [CNT_W-1:0]  count,
  input  logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] rdata
);
  logic              sts_v_q, sts_v_d, cnt_v_q, cnt_v_d;
  logic [BYTE_W-1:0] sts_q, sts_d;
  logic [CNT_W-1:0]  lat_q, lat_d, src;
  byte_ph_e          ph_q, ph_d;

  assign src   = cnt_v_q ? lat_q : count;
  assign rdata = sts_v_q ? sts_q : ((ph_q == PH_HI) ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0]);

  always_comb begin
    sts_v_d = sts_v_q;
    cnt_v_d = cnt_v_q;
    sts_d   = sts_q;
    lat_d   = lat_q;
    ph_d    = ph_q;
    if (cfg_wr) begin
      sts_v_d = 1'b0;
      cnt_v_d = 1'b0;
      ph_d    = PH_LO;
    end else if (rb_cnt || rb_sts) begin
      if (rb_sts && !sts_v_q) begin
        sts_v_d = 1'b1;
        sts_d   = status;
      end
      if (rb_cnt && !cnt_v_q) begin
        cnt_v_d = 1'b1;
        lat_d   = count;
        ph_d    = PH_LO;
      end
    end else if (rd) begin
      if (sts_v_q) begin
        sts_v_d = 1'b0;
      end else begin
        ph_d = (ph_q == PH_LO) ? PH_HI : PH_LO;
        if (ph_q == PH_HI) cnt_v_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_v_q <= 1'b0;
      cnt_v_q <= 1'b0;
      sts_q   <= '0;
      lat_q   <= '0;
      ph_q    <= PH_LO;
    end else begin
      sts_v_q <= sts_v_d;
      cnt_v_q <= cnt_v_d;
      sts_q   <= sts_d;
      lat_q   <= lat_d;
      ph_q    <= ph_d;
    end
  end

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_v_q && !rd && !cfg_wr |=> $stable(lat_q) && cnt_v_q);
endmodule

// File: rtl/pit_gate_channel.sv
module pit_gate_channel
  import pit_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              timer_out,
  output logic              spkr_out
);
  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic [BYTE_W-1:0] sys_q, lo_q, cnt_rdata, status;
  logic [5:0]        cw_q;
  logic [CNT_W-1:0]  count;
  logic              gate, spk_en, cfg_wr, rb_cnt, rb_sts, load_wr, null_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  pit_sysctl u_sys (
    .clk(clk), .rst_n(rst_i_n),
    .wr(bus_wr && (bus_addr == ADR_SYS)), .wdata(bus_wdata),
    .reg_q(sys_q), .gate(gate), .spk_en(spk_en));

  pit_prog u_prog (
    .clk(clk), .rst_n(rst_i_n),
    .wr_ctrl(bus_wr && (bus_addr == ADR_CTRL)),
    .wr_data(bus_wr && (bus_addr == ADR_DATA)),
    .wdata(bus_wdata), .cw_q(cw_q), .cfg_wr(cfg_wr),
    .rb_cnt(rb_cnt), .rb_sts(rb_sts), .load_wr(load_wr), .lo_q(lo_q));

  pit_count_core #(.CW(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_i_n), .tick_en(tick_en), .gate(gate),
    .cfg_wr(cfg_wr), .load_wr(load_wr), .square(cw_q[2:1] == 2'b11),
    .reload_in({bus_wdata, lo_q}), .cnt_q(count), .out_q(timer_out), .null_q(null_q));

  assign status = {timer_out, null_q, cw_q};

  pit_readout u_rd (
    .clk(clk), .rst_n(rst_i_n), .rd(bus_rd && (bus_addr == ADR_DATA)),
    .cfg_wr(cfg_wr), .rb_cnt(rb_cnt), .rb_sts(rb_sts),
    .count(count), .status(status), .rdata(cnt_rdata));

  always_comb begin
    case (bus_addr)
      ADR_DATA: bus_rdata = cnt_rdata;
      ADR_SYS:  bus_rdata = sys_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign spkr_out = timer_out && spk_en;

  // R7
  spk_mute_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !sys_q[1] |-> !spkr_out);
endmodule

// File: tb/tb_pit_gate_channel.sv
`timescale 1ns/1ps
module tb_pit_gate_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] bus_addr = 2'd3;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       timer_out, spkr_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  pit_gate_channel dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .timer_out(timer_out), .spkr_out(spkr_out));

  always #2.5 clk = ~clk;

  // monitor: compares each read byte with the next scoreboard entry
  always @(negedge clk) begin
    #1;
    if (bus_rd && !done) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read actual=%02h expected=%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit with_tick = 1'b0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_en = with_tick;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0; bus_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 2'd3;
  endtask

  task automatic tick();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic pins(input logic eo, input logic es, input string t);
    #1;
    checks++;
    if (timer_out !== eo || spkr_out !== es) begin
      errors++;
      $display("FAIL %s: out/spk actual=%b%b expected=%b%b", t, timer_out, spkr_out, eo, es);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    pins(1'b1, 1'b0, "R1");
    rd(2'd2, 8'h00, "R1 sysreg");
    wr(2'd1, 8'hC8);
    rd(2'd0, 8'hC4, "R1 status");
    rd(2'd0, 8'h00, "R1 cnt lo");
    rd(2'd0, 8'h00, "R1 cnt hi");

    // R2 / R10 square mode programmed, null count set
    wr(2'd2, 8'h03);
    wr(2'd1, 8'hB6);
    wr(2'd1, 8'hC8);
    rd(2'd0, 8'hF6, "R2 R10 status");
    rd(2'd0, 8'h00, "R9 lo");
    rd(2'd0, 8'h00, "R9 hi");

    // R3 reload 0x0004, load on first gated tick
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h00);
    tick();
    wr(2'd1, 8'hC8);
    rd(2'd0, 8'hB6, "R3 R10 status");
    rd(2'd0, 8'h04, "R3 cnt lo");
    rd(2'd0, 8'h00, "R3 cnt hi");
    pins(1'b1, 1'b1, "R4 N4 count4");

    // R4 even period
    tick(); pins(1'b1, 1'b1, "R4 N4 count3");
    tick(); pins(1'b0, 1'b0, "R4 N4 count2");
    tick(); pins(1'b0, 1'b0, "R4 N4 count1");
    tick(); pins(1'b1, 1'b1, "R4 N4 reload");

    // R4 odd period, reload 5
    wr(2'd0, 8'h05);
    wr(2'd0, 8'h00);
    tick(); pins(1'b1, 1'b1, "R4 N5 count5");
    tick(); pins(1'b1, 1'b1, "R4 N5 count4");
    tick(); pins(1'b1, 1'b1, "R4 N5 count3");
    tick(); pins(1'b0, 1'b0, "R4 N5 count2");
    tick(); pins(1'b0, 1'b0, "R4 N5 count1");
    tick(); pins(1'b1, 1'b1, "R4 N5 reload");

    // R6 gate cleared on the same edge as a tick: that tick still counts
    wr(2'd2, 8'h00, 1'b1);
    pins(1'b1, 1'b0, "R7 speaker muted");
    tick(); tick(); tick();
    pins(1'b1, 1'b0, "R6 out frozen");
    rd(2'd0, 8'h04, "R6 R13 live lo");
    rd(2'd0, 8'h00, "R6 R13 live hi");

    // R6 gate set on the same edge as a tick: that tick does not count
    wr(2'd2, 8'h0F, 1'b1);
    rd(2'd0, 8'h04, "R6 reenable edge lo");
    rd(2'd0, 8'h00, "R6 reenable edge hi");

    // R8 resume from held count
    tick();
    rd(2'd0, 8'h03, "R8 resume lo");
    rd(2'd0, 8'h00, "R8 resume hi");
    pins(1'b1, 1'b1, "R8 out");
    tick(); pins(1'b0, 1'b0, "R7 follow low");
    tick(); pins(1'b0, 1'b0, "R4 count1");
    tick(); pins(1'b1, 1'b1, "R7 follow high");
    wr(2'd2, 8'h01);
    pins(1'b1, 1'b0, "R7 routing off");

    // R11 unused bits kept
    wr(2'd2, 8'hA5);
    rd(2'd2, 8'hA5, "R11 A5");
    wr(2'd2, 8'h5A);
    rd(2'd2, 8'h5A, "R11 5A");
    wr(2'd2, 8'h0F);

    // R12 foreign-channel control word ignored
    wr(2'd1, 8'h74);
    wr(2'd1, 8'h38);
    wr(2'd1, 8'hC8);
    rd(2'd0, 8'hB6, "R12 status");
    rd(2'd0, 8'h05, "R12 lo");
    rd(2'd0, 8'h00, "R12 hi");

    // R5 rate generator, reload 3
    wr(2'd1, 8'hB4);
    wr(2'd0, 8'h03);
    wr(2'd0, 8'h00);
    tick(); pins(1'b1, 1'b1, "R5 count3");
    tick(); pins(1'b1, 1'b1, "R5 count2");
    tick(); pins(1'b0, 1'b0, "R5 count1");
    tick(); pins(1'b1, 1'b1, "R5 reload");
    tick(); pins(1'b1, 1'b1, "R5 count2b");
    tick(); pins(1'b0, 1'b0, "R5 count1b");

    // R9 latched snapshot survives further counting
    wr(2'd1, 8'hC8);
    tick(); tick();
    rd(2'd0, 8'h34, "R9 R10 status");
    rd(2'd0, 8'h01, "R9 latched lo");
    rd(2'd0, 8'h00, "R9 latched hi");
    wr(2'd1, 8'hC4);
    rd(2'd0, 8'h02, "R9 R13 other-channel readback ignored lo");
    rd(2'd0, 8'h00, "R9 R13 other-channel readback ignored hi");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule